// File: doc/BRIEF.md
# Card Data FIFO Transfer Engine

This block moves the data phase of a memory-card transfer between a host register port and a byte-wide card stream. A transfer is armed with a block count and a block length. The engine then counts down their product one byte per card handshake. In the read direction, bytes arriving from the card fill a 32-byte receive queue. In the write direction, bytes that the host has queued are sent to the card from a transmit store split into two 32-byte banks.

The host moves data with byte, halfword or word accesses. Each access carries up to as many bytes as its width. The first byte in queue order sits in the most significant byte of the access. Two level outputs ask the host (or a DMA engine) to service the queues. A data-done flag, and in the write direction a program-done flag, mark the end of a transfer. A flush strobe abandons a partly filled transmit bank and switches to the other bank. An abort strobe stops a transfer without completing it.

Top module: `card_xfer_engine`

## Requirements
- R1: The receive queue holds at most 32 bytes. `cardRxReady` is high only while a read-direction transfer is active, bytes remain, and fewer than 32 bytes are queued. When the host never reads, exactly 32 bytes are accepted.
- R2: Every byte accepted from the card sets `rxReq` at the next edge. A cycle with `hostRdEn` high clears it, unless a byte is accepted in that same cycle.
- R3: `hostWidth` selects the access size: 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes. A read of N bytes pops min(N, queued) bytes. The k-th popped byte (k = 0 first) appears in `hostRdData[8*(N-1-k) +: 8]`, and every other bit reads 0. The data is valid in the same cycle as `hostRdEn`.
- R4: A write of N bytes queues the bytes of `hostWrData[8*(N-1-k) +: 8]` for k = 0, 1, … in that order. It stops once 32 bytes are queued, and the extra bytes are lost. The edge that takes the write clears `txReq`.
- R5: While a write-direction transfer is active with bytes outstanding, the queued bytes go to the card in order, at most one per cycle, over `cardTxValid`/`cardTxReady`. `txReq` is set when such a transfer starts with a nonzero length, and again after each sent byte that leaves bytes outstanding.
- R6: `xferStart` loads the remaining count with `blkCount * blkLen`, empties both queues, and clears `dataDone`, `progDone` and `rxReq`.
- R7: One edge after the remaining count is zero in an active transfer, `active` falls and `dataDone` rises. `progDone` also rises for a write transfer and stays low for a read transfer. A zero-length transfer therefore completes on the second edge after its start.
- R8: `bankFlip` switches the transmit store to its other bank and discards every queued byte. A host write in the same cycle is dropped, and no byte is offered to the card in that cycle.
- R9: `xferAbort` ends an active transfer at once. The done flags stay unchanged, and no further card handshake takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| xferStart | input | 1 | Arm a new transfer (pulse) |
| xferWrite | input | 1 | Direction of the armed transfer: 1 = host to card |
| blkCount | input | 16 | Number of blocks |
| blkLen | input | 12 | Bytes per block |
| xferAbort | input | 1 | Stop the active transfer (pulse) |
| hostRdEn | input | 1 | Host read of the receive data register |
| hostWrEn | input | 1 | Host write of the transmit data register |
| hostWidth | input | 2 | Access size code |
| hostWrData | input | 32 | Host write data |
| hostRdData | output | 32 | Host read data, packed most significant lane first |
| bankFlip | input | 1 | Discard queued transmit bytes and switch bank |
| cardRxData | input | 8 | Byte from the card |
| cardRxValid | input | 1 | Card byte is valid |
| cardRxReady | output | 1 | Engine accepts a card byte |
| cardTxData | output | 8 | Byte to the card |
| cardTxValid | output | 1 | Engine offers a byte |
| cardTxReady | input | 1 | Card takes the byte |
| rxReq | output | 1 | Receive queue service request |
| txReq | output | 1 | Transmit queue service request |
| dataDone | output | 1 | Transfer finished |
| progDone | output | 1 | Write transfer finished |
| active | output | 1 | Transfer in progress |

## Verification
The bench stalls the host until the receive queue is full, which exposes an engine that accepts a 33rd byte or stops short of 32. It overfills the transmit queue, which catches a design that keeps or shifts the lost bytes, and it mixes access widths on an almost-empty receive queue, where a wrong lane order or non-zero empty lanes show at once. A flush with a write in the same cycle, a zero-length transfer and an abort followed by a restart are aimed at designs that send stale bank data, never finish a zero-length transfer, or keep shaking hands (or leave old bytes queued) after an abort.

// File: rtl/cxe_pkg.sv
package cxe_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic clearFifos;
    logic rxPush;
    logic txPop;
  } engStrobe_t;

  // access width code -> byte count
  function automatic logic [2:0] accessBytes(input logic [1:0] code);
    case (code)
      2'd0:    accessBytes = 3'd1;
      2'd1:    accessBytes = 3'd2;
      default: accessBytes = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/cxe_datapath.sv
module cxe_datapath
  import cxe_pkg::*;
#(
  parameter int RX_DEPTH   = 32,
  parameter int BANK_DEPTH = 32,
  parameter int CNT_W      = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  engStrobe_t       stb,
  input  logic             hostRdEn,
  input  logic             hostWrEn,
  input  logic [1:0]       hostWidth,
  input  logic [31:0]      hostWrData,
  input  logic             bankFlip,
  input  logic [7:0]       cardRxData,
  output logic [31:0]      hostRdData,
  output logic [7:0]       cardTxData,
  output logic [CNT_W-1:0] rxCount,
  output logic [CNT_W-1:0] txCount
);
  localparam int RX_PW   = $clog2(RX_DEPTH);
  localparam int BANK_PW = $clog2(BANK_DEPTH);

  logic [7:0]         rxMem [RX_DEPTH];
  logic [7:0]         txMem [2*BANK_DEPTH];
  logic [RX_PW-1:0]   rxRd;
  logic [BANK_PW-1:0] txRd;
  logic               txBank;
  logic [2:0]         nBytes, popN, pushN;
  logic [CNT_W-1:0]   txSpace;

  assign nBytes = accessBytes(hostWidth);

  always_comb begin
    popN = '0;
    if (hostRdEn && !stb.clearFifos)
      popN = (CNT_W'(nBytes) <= rxCount) ? nBytes : rxCount[2:0];
    txSpace = CNT_W'(BANK_DEPTH) - txCount;
    pushN = '0;
    if (hostWrEn && !bankFlip && !stb.clearFifos)
      pushN = (CNT_W'(nBytes) <= txSpace) ? nBytes : txSpace[2:0];
  end

  // first popped byte lands in the top lane of the access
  always_comb begin
    hostRdData = '0;
    for (int i = 0; i < 4; i++)
      if (i < int'(popN))
        hostRdData[8*(int'(nBytes)-1-i) +: 8] = rxMem[rxRd + RX_PW'(i)];
  end

  assign cardTxData = txMem[{txBank, txRd}];

  always_ff @(posedge clk) begin
    if (stb.rxPush)
      rxMem[rxRd + RX_PW'(rxCount)] <= cardRxData;
    for (int i = 0; i < 4; i++)
      if (i < int'(pushN))
        txMem[{txBank, txRd + BANK_PW'(txCount) + BANK_PW'(i)}] <=
          hostWrData[8*(int'(nBytes)-1-i) +: 8];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxRd    <= '0;
      rxCount <= '0;
      txRd    <= '0;
      txCount <= '0;
      txBank  <= 1'b0;
    end else if (stb.clearFifos) begin
      rxRd    <= '0;
      rxCount <= '0;
      txRd    <= '0;
      txCount <= '0;
    end else begin
      rxRd    <= rxRd + RX_PW'(popN);
      rxCount <= rxCount + CNT_W'(stb.rxPush) - CNT_W'(popN);
      if (bankFlip) begin
        txBank  <= ~txBank;
        txRd    <= '0;
        txCount <= '0;
      end else begin
        txRd    <= txRd + BANK_PW'(stb.txPop);
        txCount <= txCount + CNT_W'(pushN) - CNT_W'(stb.txPop);
      end
    end
  end

  a_r1_rx_bound: assert property (@(posedge clk) disable iff (!rstN)
    rxCount <= CNT_W'(RX_DEPTH));
  a_r4_tx_bound: assert property (@(posedge clk) disable iff (!rstN)
    txCount <= CNT_W'(BANK_DEPTH));
  a_r8_flip_empties: assert property (@(posedge clk) disable iff (!rstN)
    (bankFlip && !stb.clearFifos) |=> (txCount == '0));
  a_r3_pop_limit: assert property (@(posedge clk) disable iff (!rstN)
    (hostRdEn && !stb.clearFifos) |=> (rxCount <= $past(rxCount) + CNT_W'(1)));

endmodule

// File: rtl/cxe_ctrl.sv
module cxe_ctrl
  import cxe_pkg::*;
#(
  parameter int RX_DEPTH   = 32,
  parameter int BANK_DEPTH = 32,
  parameter int CNT_W      = 6,
  parameter int BLKCNT_W   = 16,
  parameter int BLKLEN_W   = 12,
  parameter int REM_W      = BLKCNT_W + BLKLEN_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                xferStart,
  input  logic                xferWrite,
  input  logic [BLKCNT_W-1:0] blkCount,
  input  logic [BLKLEN_W-1:0] blkLen,
  input  logic                xferAbort,
  input  logic                hostRdEn,
  input  logic                hostWrEn,
  input  logic                bankFlip,
  input  logic                cardRxValid,
  input  logic                cardTxReady,
  input  logic [CNT_W-1:0]    rxCount,
  input  logic [CNT_W-1:0]    txCount,
  output engStrobe_t          stb,
  output logic                cardRxReady,
  output logic                cardTxValid,
  output logic                rxReq,
  output logic                txReq,
  output logic                dataDone,
  output logic                progDone,
  output logic                active
);
  logic [REM_W-1:0] remaining, loadCount;
  logic             dirWrite, moving, quiet;

  assign loadCount = REM_W'(blkCount) * REM_W'(blkLen);
  assign quiet     = !xferStart && !xferAbort;
  assign moving    = active && (remaining != '0) && quiet;

  assign cardRxReady = moving && !dirWrite && (rxCount < CNT_W'(RX_DEPTH));
  assign cardTxValid = moving && dirWrite && (txCount != '0) && !bankFlip;

  assign stb.clearFifos = xferStart;
  assign stb.rxPush     = cardRxValid && cardRxReady;
  assign stb.txPop      = cardTxValid && cardTxReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active    <= 1'b0;
      dirWrite  <= 1'b0;
      remaining <= '0;
      dataDone  <= 1'b0;
      progDone  <= 1'b0;
      rxReq     <= 1'b0;
      txReq     <= 1'b0;
    end else if (xferStart) begin
      active    <= 1'b1;
      dirWrite  <= xferWrite;
      remaining <= loadCount;
      dataDone  <= 1'b0;
      progDone  <= 1'b0;
      rxReq     <= 1'b0;
      txReq     <= xferWrite && (loadCount != '0);
    end else if (xferAbort) begin
      active <= 1'b0;
      txReq  <= 1'b0;
    end else begin
      rxReq <= (rxReq && !hostRdEn) || stb.rxPush;
      if (active && remaining == '0) begin
        active   <= 1'b0;
        dataDone <= 1'b1;
        progDone <= dirWrite;
        txReq    <= 1'b0;
      end else begin
        remaining <= remaining - REM_W'(stb.rxPush || stb.txPop);
        txReq     <= (txReq && !hostWrEn) ||
                     (stb.txPop && remaining != REM_W'(1));
      end
    end
  end

  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    dataDone |-> !active);
  a_r7_prog_with_data: assert property (@(posedge clk) disable iff (!rstN)
    progDone |-> dataDone);
  a_r6_load: assert property (@(posedge clk) disable iff (!rstN)
    xferStart |=> (active && remaining == $past(loadCount) && rxCount == '0));
  a_r9_abort_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (xferAbort && !xferStart) |=> (!active && $stable(dataDone)));
  a_r5_count_step: assert property (@(posedge clk) disable iff (!rstN)
    (stb.txPop || stb.rxPush) |=> (remaining == $past(remaining) - REM_W'(1)));

endmodule

// File: rtl/card_xfer_engine.sv
module card_xfer_engine
  import cxe_pkg::*;
#(
  parameter int RX_DEPTH   = 32,
  parameter int BANK_DEPTH = 32,
  parameter int BLKCNT_W   = 16,
  parameter int BLKLEN_W   = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                xferStart,
  input  logic                xferWrite,
  input  logic [BLKCNT_W-1:0] blkCount,
  input  logic [BLKLEN_W-1:0] blkLen,
  input  logic                xferAbort,
  input  logic                hostRdEn,
  input  logic                hostWrEn,
  input  logic [1:0]          hostWidth,
  input  logic [31:0]         hostWrData,
  output logic [31:0]         hostRdData,
  input  logic                bankFlip,
  input  logic [7:0]          cardRxData,
  input  logic                cardRxValid,
  output logic                cardRxReady,
  output logic [7:0]          cardTxData,
  output logic                cardTxValid,
  input  logic                cardTxReady,
  output logic                rxReq,
  output logic                txReq,
  output logic                dataDone,
  output logic                progDone,
  output logic                active
);
  localparam int MAX_DEPTH = (RX_DEPTH > BANK_DEPTH) ? RX_DEPTH : BANK_DEPTH;
  localparam int CNT_W     = $clog2(MAX_DEPTH) + 1;
  localparam int REM_W     = BLKCNT_W + BLKLEN_W;

  engStrobe_t       stb;
  logic [CNT_W-1:0] rxCount, txCount;

  cxe_ctrl #(
    .RX_DEPTH(RX_DEPTH), .BANK_DEPTH(BANK_DEPTH), .CNT_W(CNT_W),
    .BLKCNT_W(BLKCNT_W), .BLKLEN_W(BLKLEN_W), .REM_W(REM_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .xferStart(xferStart), .xferWrite(xferWrite),
    .blkCount(blkCount), .blkLen(blkLen), .xferAbort(xferAbort),
    .hostRdEn(hostRdEn), .hostWrEn(hostWrEn), .bankFlip(bankFlip),
    .cardRxValid(cardRxValid), .cardTxReady(cardTxReady),
    .rxCount(rxCount), .txCount(txCount), .stb(stb),
    .cardRxReady(cardRxReady), .cardTxValid(cardTxValid),
    .rxReq(rxReq), .txReq(txReq), .dataDone(dataDone),
    .progDone(progDone), .active(active)
  );

  cxe_datapath #(
    .RX_DEPTH(RX_DEPTH), .BANK_DEPTH(BANK_DEPTH), .CNT_W(CNT_W)
  ) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .hostRdEn(hostRdEn),
    .hostWrEn(hostWrEn), .hostWidth(hostWidth), .hostWrData(hostWrData),
    .bankFlip(bankFlip), .cardRxData(cardRxData), .hostRdData(hostRdData),
    .cardTxData(cardTxData), .rxCount(rxCount), .txCount(txCount)
  );

endmodule

// File: tb/tb_card_xfer_engine.sv
module tb_card_xfer_engine;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        xferStart = 0, xferWrite = 0, xferAbort = 0;
  logic [15:0] blkCount = '0;
  logic [11:0] blkLen = '0;
  logic        hostRdEn = 0, hostWrEn = 0, bankFlip = 0;
  logic [1:0]  hostWidth = '0;
  logic [31:0] hostWrData = '0;
  logic [31:0] hostRdData;
  logic [7:0]  cardRxData = '0;
  logic        cardRxValid = 0, cardTxReady = 0;
  logic        cardRxReady, cardTxValid, rxReq, txReq, dataDone, progDone, active;
  logic [7:0]  cardTxData;

  card_xfer_engine dut (.*);

  always #4 clk = ~clk;  // 125 MHz

  int total = 0, bad = 0;
  int rxIdx = 0, popIdx = 0, rxBase = 0;
  logic rxEn = 0, txEn = 0;
  logic [7:0] txExp[$];
  logic [7:0] txGot[$];

  function automatic logic [7:0] pat(input int k);
    return 8'(k * 37 + 11);
  endfunction

  function automatic int widthN(input logic [1:0] w);
    return (w == 2'd0) ? 1 : (w == 2'd1) ? 2 : 4;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // card models: drive at negedge, count handshakes late in the cycle
  always @(negedge clk) begin
    cardRxValid <= rxEn && ($urandom % 4 != 0);
    cardRxData  <= pat(rxIdx);
    cardTxReady <= txEn && ($urandom % 3 != 0);
  end

  always begin
    @(posedge clk);
    #7;
    if (cardRxValid && cardRxReady) rxIdx++;
    if (cardTxValid && cardTxReady) txGot.push_back(cardTxData);
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startXfer(input bit wr, input int cnt, input int len);
    @(negedge clk);
    xferStart = 1; xferWrite = wr; blkCount = 16'(cnt); blkLen = 12'(len);
    popIdx = rxIdx; rxBase = rxIdx;
    txExp.delete(); txGot.delete();
    @(posedge clk); #1;
    xferStart = 0;
  endtask

  task automatic hostRead(input logic [1:0] w);
    int n, avail, m;
    logic [31:0] exp;
    @(negedge clk);
    hostRdEn = 1; hostWidth = w;
    #1;
    n = widthN(w); avail = rxIdx - popIdx; m = (n < avail) ? n : avail;
    exp = '0;
    for (int i = 0; i < m; i++) exp[8*(n-1-i) +: 8] = pat(popIdx + i);
    check(hostRdData == exp, "R3 read packing", hostRdData, exp);
    popIdx += m;
    @(posedge clk); #1;
    hostRdEn = 0;
  endtask

  task automatic hostWrite(input logic [1:0] w, input logic [31:0] d);
    int n, occ, m;
    @(negedge clk);
    hostWrEn = 1; hostWidth = w; hostWrData = d;
    #1;
    n = widthN(w); occ = txExp.size() - txGot.size();
    m = (n < 32 - occ) ? n : 32 - occ;
    for (int i = 0; i < m; i++) txExp.push_back(d[8*(n-1-i) +: 8]);
    @(posedge clk); #1;
    hostWrEn = 0;
  endtask

  task automatic flush(input bit withWrite, input logic [31:0] d);
    @(negedge clk);
    bankFlip = 1;
    if (withWrite) begin hostWrEn = 1; hostWidth = 2'd2; hostWrData = d; end
    #1;
    check(cardTxValid == 1'b0, "R8 no offer during flip", cardTxValid, 0);
    while (txExp.size() > txGot.size()) void'(txExp.pop_back());
    @(posedge clk); #1;
    bankFlip = 0; hostWrEn = 0;
  endtask

  task automatic waitDone();
    int k = 0;
    while (!dataDone && k < 3000) begin @(negedge clk); k++; end
    #1;
    check(dataDone == 1'b1 && active == 1'b0, "R7 done reached", {dataDone, active}, 2'b10);
  endtask

  task automatic readAll(input int bytes);
    while (popIdx - rxBase < bytes) hostRead(2'($urandom % 3));
  endtask

  task automatic writeAll(input int bytes);
    while (txGot.size() < bytes) begin
      if (txExp.size() < bytes && (txExp.size() - txGot.size()) < 32)
        hostWrite(2'($urandom % 4), $urandom);
      else
        @(negedge clk);
    end
  endtask

  task automatic compareTx(input int bytes, input string req);
    int mism = 0;
    for (int i = 0; i < txGot.size(); i++)
      if (i >= txExp.size() || txGot[i] != txExp[i]) mism++;
    check(txGot.size() == bytes && mism == 0, req, txGot.size(), bytes);
  endtask

  initial begin
    int lenA, held;
    logic [31:0] wordB;
    void'($urandom(32'h5eed_c0de));
    cyc(3);
    #1 rstN = 1;
    cyc(1); #1;
    // reset state
    check({active, rxReq, txReq, dataDone, progDone} == 5'b0, "R7 reset flags",
          {active, rxReq, txReq, dataDone, progDone}, 0);
    check({cardRxReady, cardTxValid} == 2'b0, "R1 reset handshakes",
          {cardRxReady, cardTxValid}, 0);

    // R1/R2: read transfer, host stalled until the queue fills
    rxEn = 1;
    startXfer(0, 3, 20);
    cyc(120); #1;
    check(rxIdx - rxBase == 32, "R1 queue holds 32", rxIdx - rxBase, 32);
    check(cardRxReady == 1'b0, "R1 ready low when full", cardRxReady, 0);
    check(rxReq == 1'b1, "R2 request set", rxReq, 1);
    rxEn = 0;
    cyc(2);
    hostRead(2'd2);
    check(rxReq == 1'b0, "R2 read clears request", rxReq, 0);
    hostRead(2'd0);
    hostRead(2'd1);
    rxEn = 1;
    readAll(60);
    waitDone();
    check(rxIdx - rxBase == 60, "R6 count is blocks times length", rxIdx - rxBase, 60);
    check(progDone == 1'b0, "R7 read has no program-done", progDone, 0);
    rxEn = 0;
    cyc(2);

    // R4/R5: overfilled transmit queue
    txEn = 0;
    startXfer(1, 1, 40);
    check(txReq == 1'b1, "R5 request at start", txReq, 1);
    hostWrite(2'd2, 32'hA1B2C3D4);
    check(txReq == 1'b0, "R4 write clears request", txReq, 0);
    for (int i = 0; i < 9; i++) hostWrite(2'd2, $urandom);
    check(txExp.size() == 32, "R4 queue stops at 32", txExp.size(), 32);
    txEn = 1;
    cyc(6); #1;
    check(txReq == 1'b1, "R5 request after drained byte", txReq, 1);
    check(txGot.size() > 0 && txGot[0] == 8'hA1, "R4 most significant lane first",
          txGot.size() > 0 ? txGot[0] : 0, 8'hA1);
    writeAll(40);
    waitDone();
    compareTx(40, "R5 transmit stream order");
    check(progDone == 1'b1, "R7 write sets program-done", progDone, 1);

    // R8: flush discards queued bytes, same-cycle write dropped
    txEn = 0;
    startXfer(1, 2, 4);
    hostWrite(2'd2, 32'h11223344);
    cyc(1); #1;
    check(cardTxValid == 1'b1, "R8 byte offered before flip", cardTxValid, 1);
    flush(1, 32'hDEADBEEF);
    wordB = 32'h5566_7788;
    hostWrite(2'd2, wordB);
    hostWrite(2'd1, 32'h0000_99AA);
    hostWrite(2'd0, 32'h0000_00BB);
    hostWrite(2'd0, 32'h0000_00CC);
    txEn = 1;
    waitDone();
    compareTx(8, "R8 stream after flip");
    check(txGot.size() > 0 && txGot[0] == 8'h55, "R8 first byte from new bank",
          txGot.size() > 0 ? txGot[0] : 0, 8'h55);
    txEn = 0;

    // R7: zero-length transfer
    startXfer(0, 0, 5);
    check(active == 1'b1 && dataDone == 1'b0, "R7 zero length armed", {active, dataDone}, 2'b10);
    @(posedge clk); #1;
    check(active == 1'b0 && dataDone == 1'b1, "R7 zero length completes", {active, dataDone}, 2'b01);

    // R9/R6: abort then restart
    rxEn = 1;
    startXfer(0, 4, 25);
    check(dataDone == 1'b0, "R6 start clears done", dataDone, 0);
    cyc(20);
    @(negedge clk); xferAbort = 1;
    @(posedge clk); #1; xferAbort = 0;
    check(active == 1'b0 && dataDone == 1'b0, "R9 abort without done", {active, dataDone}, 0);
    held = rxIdx;
    cyc(10); #1;
    check(rxIdx == held && cardRxReady == 1'b0, "R9 no handshake after abort", rxIdx, held);
    rxEn = 0;
    cyc(2);
    startXfer(0, 1, 4);
    hostRead(2'd2);  // model expects zero: queue emptied by start (R6)
    @(negedge clk); xferAbort = 1;
    @(posedge clk); #1; xferAbort = 0;

    // constrained random transfers
    rxEn = 1; txEn = 1;
    for (int t = 0; t < 10; t++) begin
      bit wr;
      int cnt, len;
      wr = 1'($urandom % 2); cnt = 1 + $urandom % 4; len = 1 + $urandom % 40;
      lenA = cnt * len;
      startXfer(wr, cnt, len);
      if (wr) begin
        writeAll(lenA);
        waitDone();
        compareTx(lenA, "R5 random write stream");
      end else begin
        readAll(lenA);
        waitDone();
        check(rxIdx - rxBase == lenA, "R1 random read count", rxIdx - rxBase, lenA);
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule